// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a processor subsystem. The oscillator clock goes through a fixed divider and then through a selectable binary divider. The result advances an 8-bit up counter. When the counter reaches its top value, the block emits one long pulse. By default the pulse drives an active-low reset output. If the interrupt route is enabled, the pulse drives an active-high wake/interrupt output instead, which can bring the device out of idle or standby.

Software keeps the timer from expiring by writing a two-byte service sequence into the key register. It can also stop the timer with a disable bit. Every write to the control register must carry a fixed check pattern. A write with any other pattern is treated as tampering and fires the reset pulse at once.

Register access is a plain single-cycle write port plus a combinational read port. There is no handshake and no back-pressure: each write with `wr_en` high is taken at that clock edge. Register addresses are 0 for control, 1 for key and 2 for counter readback. Clock selection and low-power sequencing are handled elsewhere.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the counter reads 0, control readback is 0x00, `wdt_rst_n` is 1 and `wake_pulse` is 0. At reset the timer is enabled, the prescale select is 0 and the pulse is routed to reset.
- R2: When enabled, the counter advances by one every BASE_DIV×D clocks, counted from the last service or pulse start. D is 1 for select 0 and 2^(s-1) for select s in 1..7.
- R3: One clock after the counter reads 255 (timer enabled), the pulse starts and the counter reads 0.
- R4: The pulse lasts exactly PULSE_LEN clocks (default 512). On the reset route, `wdt_rst_n` is low for that whole time.
- R5: Writing 0x55 and then 0xAA to the key register clears the counter and the prescaler on the 0xAA write. A repeated 0x55 keeps the sequence armed.
- R6: A key byte other than 0x55 or 0xAA never clears the counter and disarms the sequence. An 0xAA write that does not follow an armed 0x55 has no effect.
- R7: While the disable bit is set, the counter holds its value and no overflow pulse occurs. Key service still clears the counter.
- R8: The control byte holds the check field in bits [5:3], and it must be 3'b101. Any other value starts the pulse on the reset route at the write edge, whatever the route bit is. The other fields are still written.
- R9: With the route bit set, an overflow raises `wake_pulse` for PULSE_LEN clocks while `wdt_rst_n` stays high.
- R10: A bad check write or overflow during an active pulse neither restarts nor extends it.
- R11: The control layout is: bit 7 route-to-interrupt, bit 6 disable, bits [5:3] check, bits [2:0] prescale select. Control reads back as {route, disable, 3'b000, select}. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| wr_addr | input | 2 | Write address: 0 control, 1 key |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 2 counter |
| rd_data | output | 8 | Combinational read data |
| wdt_rst_n | output | 1 | Active-low reset pulse |
| wake_pulse | output | 1 | Active-high interrupt/wake pulse |

## Verification
The hardest states to reach from the ports are the slow ones. These are an overflow at the largest prescale select, and a counter frozen at a known nonzero value so that a failed service can be seen. The bench builds with small BASE_DIV and PULSE_LEN and sweeps every prescale select through a complete overflow, predicting the exact edge of each count and pulse. To test the key detector, it parks the counter by disabling it after a short run. It then sweeps every first key byte before 0xAA, and every byte placed between 0x55 and 0xAA. A separate pass sweeps all eight check patterns. Pulse extension is provoked by a second bad write placed inside a running pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PS_W     = 3;
  localparam int PS_LO    = 0;
  localparam int CHK_LO   = 3;
  localparam int DIS_BIT  = 6;
  localparam int IRQ_BIT  = 7;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_KEY  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  typedef struct packed {
    logic            route_irq;
    logic            disable_cnt;
    logic [PS_W-1:0] ps_sel;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int BASE_DIV = 512,
  parameter int PS_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick
);
  localparam int BW    = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int SEL_W = (1 << PS_W) - 2;

  logic [BW-1:0]    base_q;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] mask;
  logic             base_tick;

  assign base_tick = (base_q == BW'(BASE_DIV - 1));

  always_comb begin
    for (int i = 0; i < SEL_W; i++) begin
      mask[i] = ((i + 1) < int'(ps_sel));
    end
  end

  assign tick = !hold && base_tick && ((sel_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= '0;
    end else if (hold) begin
      base_q <= '0;
      sel_q  <= '0;
    end else if (base_tick) begin
      base_q <= '0;
      sel_q  <= sel_q + 1'b1;
    end else begin
      base_q <= base_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keydet.sv
module wdog_keydet #(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] KEY_ARM = 8'h55,
  parameter logic [DW-1:0] KEY_SVC = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          svc_clear
);
  logic armed_q;

  assign svc_clear = key_wr && armed_q && (key_data == KEY_SVC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (key_wr) begin
      armed_q <= (key_data == KEY_ARM);
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic bad_evt,
  input  logic route_irq,
  output logic active,
  output logic to_irq
);
  localparam int LW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      to_irq <= 1'b0;
      len_q  <= '0;
    end else if (!active) begin
      if (ovf_evt || bad_evt) begin
        active <= 1'b1;
        to_irq <= route_irq && !bad_evt;
        len_q  <= '0;
      end
    end else if (len_q == LW'(PULSE_LEN - 1)) begin
      active <= 1'b0;
      len_q  <= '0;
    end else begin
      len_q <= len_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed import wdog_pkg::*; #(
  parameter int         CNT_W     = 8,
  parameter int         BASE_DIV  = 512,
  parameter int         PULSE_LEN = 512,
  parameter int         DW        = 8,
  parameter logic [7:0] KEY_ARM   = 8'h55,
  parameter logic [7:0] KEY_SVC   = 8'hAA,
  parameter logic [2:0] CHECK_OK  = 3'b101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          wdt_rst_n,
  output logic          wake_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, key_wr, bad_wr, svc_clear;
  logic             fire, hold, tick, pulse_active, pulse_irq;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign key_wr  = wr_en && (wr_addr == ADDR_KEY);
  assign bad_wr  = ctrl_wr && (wr_data[CHK_LO +: 3] != CHECK_OK);
  assign fire    = (cnt_q == CNT_MAX) && !ctrl_q.disable_cnt;
  assign hold    = ctrl_q.disable_cnt || svc_clear || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.route_irq   <= wr_data[IRQ_BIT];
      ctrl_q.disable_cnt <= wr_data[DIS_BIT];
      ctrl_q.ps_sel      <= wr_data[PS_LO +: PS_W];
    end
  end

  wdog_prescale #(.BASE_DIV(BASE_DIV), .PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(hold), .ps_sel(ctrl_q.ps_sel), .tick(tick)
  );

  wdog_keydet #(.DW(DW), .KEY_ARM(DW'(KEY_ARM)), .KEY_SVC(DW'(KEY_SVC))) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data), .svc_clear(svc_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (svc_clear || fire) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ovf_evt(fire), .bad_evt(bad_wr),
    .route_irq(ctrl_q.route_irq), .active(pulse_active), .to_irq(pulse_irq)
  );

  assign wdt_rst_n  = !(pulse_active && !pulse_irq);
  assign wake_pulse = pulse_active && pulse_irq;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[IRQ_BIT]          = ctrl_q.route_irq;
        rd_data[DIS_BIT]          = ctrl_q.disable_cnt;
        rd_data[PS_LO +: PS_W]    = ctrl_q.ps_sel;
      end
      ADDR_CNT:  rd_data = DW'(cnt_q);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             dis,
  input logic             svc,
  input logic             bad,
  input logic             active,
  input logic             wdt_rst_n,
  input logic             wake_pulse
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (active) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) !(!wdt_rst_n && wake_pulse)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == '0)); // R2
  AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) svc |=> (cnt == '0)); // R5
  AST_DIS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (dis && !svc) |=> (cnt == $past(cnt))); // R7
  AST_BAD_RESET: assert property (@(posedge clk) disable iff (!rst_n) (bad && !active) |=> !wdt_rst_n); // R8
  AST_OVF_FIRE: assert property (@(posedge clk) disable iff (!rst_n) (cnt == TOP && !dis && !active) |=> (active && cnt == '0)); // R3
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n) run_q <= RW'(PULSE_LEN)); // R4
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .dis(ctrl_q.disable_cnt), .svc(svc_clear),
  .bad(bad_wr), .active(pulse_active), .wdt_rst_n(wdt_rst_n), .wake_pulse(wake_pulse)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
  localparam int B = 2;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = 2'd2;
  logic [7:0] rd_data;
  logic wdt_rst_n, wake_pulse;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_keyed #(.BASE_DIV(B), .PULSE_LEN(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst_n(wdt_rst_n), .wake_pulse(wake_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic service();
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
  endtask

  function automatic int cnt_now();
    return int'(rd_data);
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic overflow_run(input int k, input bit irq);
    int d = (k == 0) ? 1 : (1 << (k - 1));
    int bd = B * d;
    rd_addr = 2'd2;
    wr(2'd0, 8'h28 | (irq ? 8'h80 : 8'h00) | 8'(k));
    service();
    chk("R5 clear", cnt_now(), 0);
    waitn(bd);
    chk("R2 first step", cnt_now(), 1);
    waitn(bd * 100);
    chk("R2 mid count", cnt_now(), 101);
    waitn(bd * 154);
    chk("R3 at top", cnt_now(), 255);
    chk("R3 no pulse yet", int'(wdt_rst_n), 1);
    waitn(1);
    chk("R3 counter restart", cnt_now(), 0);
    if (irq) begin
      chk("R9 wake high", int'(wake_pulse), 1);
      chk("R9 reset stays high", int'(wdt_rst_n), 1);
      waitn(P - 1);
      chk("R9 wake last clock", int'(wake_pulse), 1);
      waitn(1);
      chk("R9 wake ends", int'(wake_pulse), 0);
    end else begin
      chk("R3 pulse start", int'(wdt_rst_n), 0);
      chk("R4 no wake", int'(wake_pulse), 0);
      waitn(P - 1);
      chk("R4 last low clock", int'(wdt_rst_n), 0);
      waitn(1);
      chk("R4 pulse ends", int'(wdt_rst_n), 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    int t0;
    int lows;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_addr = 2'd0;
    #0.1;
    chk("R1 ctrl", int'(rd_data), 0);
    rd_addr = 2'd2;
    #0.1;
    chk("R1 cnt", int'(rd_data), 0);
    chk("R1 rst high", int'(wdt_rst_n), 1);
    chk("R1 wake low", int'(wake_pulse), 0);

    // R11 layout and readback
    wr(2'd0, 8'hEB);
    rd_addr = 2'd0;
    #0.1;
    chk("R11 ctrl readback", int'(rd_data), 8'hC3);
    chk("R11 good check no reset", int'(wdt_rst_n), 1);
    rd_addr = 2'd2;
    #0.1;
    v = cnt_now();
    waitn(3);
    chk("R11 reads side-effect free", cnt_now(), v);

    // R6 and R5: park the counter at a nonzero value
    wr(2'd0, 8'h28);
    waitn(20);
    wr(2'd0, 8'h68);
    v = cnt_now();
    chk("R7 parked nonzero", int'(v != 0), 1);
    for (int x = 0; x < 256; x++) begin
      wr(2'd1, 8'(x));
      wr(2'd1, 8'hAA);
      if (x == 8'h55) begin
        chk("R5 pair clears", cnt_now(), 0);
        wr(2'd0, 8'h28);
        waitn(20);
        wr(2'd0, 8'h68);
        v = cnt_now();
      end else begin
        chk("R6 byte then AA no clear", cnt_now(), v);
      end
    end
    for (int x = 0; x < 256; x++) begin
      if (x == 8'hAA) continue;
      wr(2'd1, 8'h55);
      wr(2'd1, 8'(x));
      wr(2'd1, 8'hAA);
      if (x == 8'h55) begin
        chk("R5 repeated arm clears", cnt_now(), 0);
        wr(2'd0, 8'h28);
        waitn(20);
        wr(2'd0, 8'h68);
        v = cnt_now();
      end else begin
        chk("R6 broken sequence", cnt_now(), v);
      end
    end

    // R7 disabled counter holds and never pulses
    lows = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (!wdt_rst_n || wake_pulse) lows++;
    end
    chk("R7 frozen count", cnt_now(), v);
    chk("R7 no pulse", lows, 0);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    chk("R7 service while disabled", cnt_now(), 0);

    // R8 sweep check patterns
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 8'h40 | 8'(c << 3));
      chk("R8 check pattern", int'(wdt_rst_n), (c == 5) ? 1 : 0);
      waitn(P + 2);
      chk("R8 pulse over", int'(wdt_rst_n), 1);
    end
    wr(2'd0, 8'hC0);
    chk("R8 bad ignores route rst", int'(wdt_rst_n), 0);
    chk("R8 bad ignores route wake", int'(wake_pulse), 0);
    rd_addr = 2'd0;
    #0.1;
    chk("R8 fields still written", int'(rd_data), 8'hC0);
    rd_addr = 2'd2;
    waitn(P + 2);

    // R10 no extension
    wr(2'd0, 8'h40);
    t0 = cyc;
    waitn(3);
    wr(2'd0, 8'h40);
    while (cyc < t0 + P - 1) @(negedge clk);
    chk("R10 still low", int'(wdt_rst_n), 0);
    @(negedge clk);
    chk("R10 not extended", int'(wdt_rst_n), 1);
    waitn(2);

    // R2 R3 R4 sweep over every prescale select
    for (int k = 0; k < 8; k++) overflow_run(k, 1'b0);
    // R9 routed to wake output
    overflow_run(0, 1'b1);
    overflow_run(2, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule